// File: doc/BRIEF.md
# GPIO Bank Controller

This block controls one bank of general-purpose pins: 16 by default, or 8 when `NUM_PINS` is set to 8. Software sets each pin's configuration through a small synchronous register bus. Each pin has a mode, a pull choice, an output type, a speed code and an alternate-function number. From these the block drives the pad-control outputs: drive enable, drive value, pull-up, pull-down, open-drain flag and speed code.

In alternate-function mode a pin is handed to one of 16 peripheral lines. That line supplies both the pin's value and its direction. Input levels pass through a two-flop synchroniser. Peripherals see them on `pin_in`, and software reads them through a register. Output bits can be set and cleared in a single write, so several agents can drive their own pins without a read-modify-write. When `SECURE_EN` is 1, each pin carries a secure attribute. A non-secure access cannot change the configuration or output bit of a secure pin.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is in analog mode (mode code 3). The MODE register (address 0) then reads all ones over its 2·NUM_PINS bits. `pad_oe`, `pad_out`, `pad_pu`, `pad_pd`, `pad_od`, `pad_speed` and `pin_in` are all zero.
- R2: Register addresses are: 0 MODE (2 bits per pin: 0 input, 1 output, 2 alternate, 3 analog), 1 PULL (2 bits per pin), 2 OTYPE (1 bit per pin, 1 = open-drain), 3 SPEED (2 bits per pin), 4 ALTSEL pins 0-7 and 5 ALTSEL pins 8-15 (4 bits per pin), 6 ODATA, 7 SETCLR, 8 IDATA, 9 SECURE. Field i sits at bits [w·i+w-1 : w·i]. A read strobed at one edge shows on `bus_rdata` after that edge. SETCLR reads as zero. A write reaches the pad outputs at the second rising edge after the write edge.
- R3: In input mode `pad_oe` is 0. `pin_in` and IDATA follow `pad_in` through two flip-flops: a pad change shows after the second rising edge, not after the first.
- R4: In analog mode `pad_pu` and `pad_pd` are 0 whatever PULL holds. `pin_in` and IDATA read 0 for that pin.
- R5: In every other mode a PULL value of 1 sets `pad_pu`, 2 sets `pad_pd`, and 0 or 3 sets neither.
- R6: In output mode with push-pull type, `pad_oe` is 1 and `pad_out` equals the pin's ODATA bit.
- R7: With open-drain type on a driving pin, `pad_out` is 0 and `pad_od` is 1. A data value of 1 releases the pad (`pad_oe` 0) and a data value of 0 drives it (`pad_oe` 1).
- R8: In alternate mode the ALTSEL number f picks line f. `alt_data[f·NUM_PINS+i]` is the pin's data and `alt_oe[f·NUM_PINS+i]` its drive enable. ALTSEL has no effect on the pads in any other mode.
- R9: A SETCLR write sets ODATA bit i for each 1 in bit i and clears it for each 1 in bit 16+i. When both bits are 1 the pin is set. Bits written as 0 leave their pins unchanged.
- R10: SECURE can be written only by an access with `bus_sec` high. A write with `bus_sec` low leaves the fields and ODATA bit of every secure pin unchanged, and still updates the non-secure pins.
- R11: A pin that is not driving (input mode, analog mode, or alternate mode with its line's enable low) shows `pad_speed` 0 and `pad_od` 0, whatever SPEED and OTYPE hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sec | input | 1 | Access is secure |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| alt_data | input | 16·NUM_PINS | Peripheral line data, line f at bits f·NUM_PINS |
| alt_oe | input | 16·NUM_PINS | Peripheral line drive enables, same layout |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| pad_od | output | NUM_PINS | Open-drain flag |
| pad_speed | output | 2·NUM_PINS | Speed code per pin |
| pin_in | output | NUM_PINS | Synchronised input to peripherals |

## Verification
The assertions assume that only one bus access happens in a cycle and that `bus_we` and `bus_re` are never high together. They also assume that SETCLR and ODATA writes arrive as whole words, so the previous cycle's strobe fully explains each change to the output bits. The bench drives every access on the falling edge, holds each strobe for exactly one cycle, and never overlaps a read with a write. It changes `pad_in` and the peripheral lines only while the bus is idle.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int NUM_ALT  = 16;
  localparam int ALT_W    = $clog2(NUM_ALT);
  localparam int CLR_BASE = 16;   // clear half of the set/clear word
  localparam int ALT_PER  = BUS_W / ALT_W; // pins per alternate-select word

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALT    = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_t;

  localparam logic [ADDR_W-1:0] A_MODE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PULL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_OTYPE  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SPEED  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ALTLO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALTHI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ODATA  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SETCLR = 4'd7;
  localparam logic [ADDR_W-1:0] A_IDATA  = 4'd8;
  localparam logic [ADDR_W-1:0] A_SECURE = 4'd9;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter bit SECURE_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic                      bus_sec,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]       in_view,
  output logic [2*NUM_PINS-1:0]     mode_q,
  output logic [2*NUM_PINS-1:0]     pull_q,
  output logic [NUM_PINS-1:0]       otype_q,
  output logic [2*NUM_PINS-1:0]     speed_q,
  output logic [ALT_W*NUM_PINS-1:0] altsel_q,
  output logic [NUM_PINS-1:0]       odata_q,
  output logic [NUM_PINS-1:0]       sec_q
);
  logic [NUM_PINS-1:0] wmask;
  logic [BUS_W-1:0]    rd_c;

  // per-pin write permission for this access
  always_comb begin
    if (SECURE_EN && !bus_sec) wmask = ~sec_q;
    else                       wmask = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '1;
      pull_q   <= '0;
      otype_q  <= '0;
      speed_q  <= '0;
      altsel_q <= '0;
      odata_q  <= '0;
      sec_q    <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) mode_q[2*i +: 2] <= bus_wdata[2*i +: 2];
        A_PULL:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) pull_q[2*i +: 2] <= bus_wdata[2*i +: 2];
        A_OTYPE:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) otype_q[i] <= bus_wdata[i];
        A_SPEED:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) speed_q[2*i +: 2] <= bus_wdata[2*i +: 2];
        A_ALTLO, A_ALTHI:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i] && ((i / ALT_PER) == int'(bus_addr == A_ALTHI)))
              altsel_q[ALT_W*i +: ALT_W] <= bus_wdata[ALT_W*(i % ALT_PER) +: ALT_W];
        A_ODATA:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) odata_q[i] <= bus_wdata[i];
        A_SETCLR:
          for (int i = 0; i < NUM_PINS; i++)
            if (wmask[i]) begin
              if (bus_wdata[i])                 odata_q[i] <= 1'b1;
              else if (bus_wdata[CLR_BASE + i]) odata_q[i] <= 1'b0;
            end
        A_SECURE:
          if (SECURE_EN && bus_sec) sec_q <= bus_wdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_c = '0;
    case (bus_addr)
      A_MODE:   rd_c[2*NUM_PINS-1:0] = mode_q;
      A_PULL:   rd_c[2*NUM_PINS-1:0] = pull_q;
      A_OTYPE:  rd_c[NUM_PINS-1:0]   = otype_q;
      A_SPEED:  rd_c[2*NUM_PINS-1:0] = speed_q;
      A_ALTLO, A_ALTHI:
        for (int i = 0; i < NUM_PINS; i++)
          if ((i / ALT_PER) == int'(bus_addr == A_ALTHI))
            rd_c[ALT_W*(i % ALT_PER) +: ALT_W] = altsel_q[ALT_W*i +: ALT_W];
      A_ODATA:  rd_c[NUM_PINS-1:0]   = odata_q;
      A_IDATA:  rd_c[NUM_PINS-1:0]   = in_view;
      A_SECURE: rd_c[NUM_PINS-1:0]   = sec_q;
      default:  rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_c;
  end
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
  import gpio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pin_mode_t          mode,
  input  logic [1:0]         pull,
  input  logic               otype,
  input  logic [1:0]         speed,
  input  logic [ALT_W-1:0]   altsel,
  input  logic               odata,
  input  logic [NUM_ALT-1:0] alt_data_v,
  input  logic [NUM_ALT-1:0] alt_oe_v,
  input  logic               in_sync,
  output logic               oe_q,
  output logic               out_q,
  output logic               pu_q,
  output logic               pd_q,
  output logic               od_q,
  output logic [1:0]         speed_q,
  output logic               pin_in
);
  logic drive, data;

  always_comb begin
    unique case (mode)
      PM_OUTPUT: begin drive = 1'b1;             data = odata;              end
      PM_ALT:    begin drive = alt_oe_v[altsel]; data = alt_data_v[altsel]; end
      default:   begin drive = 1'b0;             data = 1'b0;               end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      pu_q    <= 1'b0;
      pd_q    <= 1'b0;
      od_q    <= 1'b0;
      speed_q <= 2'b00;
    end else begin
      oe_q    <= drive & (otype ? ~data : 1'b1);
      out_q   <= drive & ~otype & data;
      od_q    <= drive & otype;
      speed_q <= drive ? speed : 2'b00;
      pu_q    <= (mode != PM_ANALOG) && (pull == 2'b01);
      pd_q    <= (mode != PM_ANALOG) && (pull == 2'b10);
    end
  end

  assign pin_in = (mode != PM_ANALOG) & in_sync;
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 16,   // 16 or 8
  parameter bit SECURE_EN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic                        bus_sec,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BUS_W-1:0]            bus_wdata,
  output logic [BUS_W-1:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]         pad_in,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_data,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_pu,
  output logic [NUM_PINS-1:0]         pad_pd,
  output logic [NUM_PINS-1:0]         pad_od,
  output logic [2*NUM_PINS-1:0]       pad_speed,
  output logic [NUM_PINS-1:0]         pin_in
);
  logic [2*NUM_PINS-1:0]     mode_w, pull_w, speed_w;
  logic [NUM_PINS-1:0]       otype_w, odata_w, sec_w, sync_w, ana_w;
  logic [ALT_W*NUM_PINS-1:0] altsel_w;

  gpio_regfile #(.NUM_PINS(NUM_PINS), .SECURE_EN(SECURE_EN)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_sec(bus_sec),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_view(pin_in),
    .mode_q(mode_w), .pull_q(pull_w), .otype_q(otype_w), .speed_q(speed_w),
    .altsel_q(altsel_w), .odata_q(odata_w), .sec_q(sec_w)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_ALT-1:0] ad, ae;
    always_comb begin
      for (int f = 0; f < NUM_ALT; f++) begin
        ad[f] = alt_data[f*NUM_PINS + p];
        ae[f] = alt_oe[f*NUM_PINS + p];
      end
    end

    assign ana_w[p] = (pin_mode_t'(mode_w[2*p +: 2]) == PM_ANALOG);

    gpio_pin_cell u_cell (
      .clk(clk), .rst(rst),
      .mode(pin_mode_t'(mode_w[2*p +: 2])),
      .pull(pull_w[2*p +: 2]),
      .otype(otype_w[p]),
      .speed(speed_w[2*p +: 2]),
      .altsel(altsel_w[ALT_W*p +: ALT_W]),
      .odata(odata_w[p]),
      .alt_data_v(ad),
      .alt_oe_v(ae),
      .in_sync(sync_w[p]),
      .oe_q(pad_oe[p]),
      .out_q(pad_out[p]),
      .pu_q(pad_pu[p]),
      .pd_q(pad_pd[p]),
      .od_q(pad_od[p]),
      .speed_q(pad_speed[2*p +: 2]),
      .pin_in(pin_in[p])
    );
  end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter bit SECURE_EN = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic                bus_sec,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_pd,
  input logic [NUM_PINS-1:0] pad_od,
  input logic [NUM_PINS-1:0] ana_w,
  input logic [NUM_PINS-1:0] sec_w,
  input logic [NUM_PINS-1:0] odata_w
);
  logic [NUM_PINS-1:0] locked;
  assign locked = (SECURE_EN && !bus_sec) ? sec_w : '0;

  // R1: pads are quiet right after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_od == '0));

  // R4: analog pins never have a pull enabled
  a_r4_analog_no_pull: assert property (@(posedge clk) disable iff (rst)
    ($past(ana_w) & (pad_pu | pad_pd)) == '0);

  // R5: pull-up and pull-down are never both on
  a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  // R7: an open-drain pin never drives high
  a_r7_od_no_high: assert property (@(posedge clk) disable iff (rst)
    (pad_od & pad_oe & pad_out) == '0);

  // R9: set bits win, clear-only bits clear, for writable pins
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    $past(bus_we && bus_addr == A_SETCLR) |->
      ((($past(bus_wdata[NUM_PINS-1:0] & ~locked)) & ~odata_w) == '0) &&
      ((($past(bus_wdata[CLR_BASE +: NUM_PINS] & ~bus_wdata[NUM_PINS-1:0] & ~locked)) & odata_w) == '0));

  // R10: non-secure writes leave secure output bits alone
  a_r10_secure_odata: assert property (@(posedge clk) disable iff (rst)
    $past(bus_we && !bus_sec) |-> ((odata_w ^ $past(odata_w)) & $past(sec_w)) == '0);

  // R10: the secure attribute changes only on a secure write to it
  a_r10_attr_locked: assert property (@(posedge clk) disable iff (rst)
    $past(!(bus_we && bus_sec && bus_addr == A_SECURE)) |-> sec_w == $past(sec_w));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .SECURE_EN(SECURE_EN)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sec(bus_sec),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .pad_od(pad_od), .ana_w(ana_w), .sec_w(sec_w), .odata_w(odata_w)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0, bus_re = 1'b0, bus_sec = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [16*N-1:0] alt_data = '0, alt_oe = '0;
  logic [N-1:0]  pad_oe, pad_out, pad_pu, pad_pd, pad_od, pin_in;
  logic [2*N-1:0] pad_speed;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_seen = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(N), .SECURE_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_sec(bus_sec),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_data(alt_data), .alt_oe(alt_oe),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_od(pad_od), .pad_speed(pad_speed), .pin_in(pin_in)
  );

  // monitor: compares read data one edge after each read strobe
  always @(posedge clk) re_seen <= bus_re;
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_sec = s;
    @(negedge clk);
    bus_we = 1'b0; bus_sec = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_pu|pd", 32'(pad_pu | pad_pd), 0);
    chk("R1 pad_od", 32'(pad_od), 0);
    chk("R1 pad_speed", 32'(pad_speed), 0);
    rd(4'd0, 32'hFFFF_FFFF, "R1 mode reset");

    // R4 analog hides input
    pad_in = 16'hA5C3;
    settle();
    chk("R4 pin_in analog", 32'(pin_in), 0);
    rd(4'd8, 32'h0, "R4 idata analog");

    // R3 input mode and sync latency
    wr(4'd0, 32'h0, 1'b0);
    settle();
    chk("R3 pin_in", 32'(pin_in), 32'hA5C3);
    chk("R3 pad_oe input", 32'(pad_oe), 0);
    rd(4'd8, 32'hA5C3, "R3 idata");
    pad_in = 16'h1234;
    @(negedge clk);
    chk("R3 sync one edge", 32'(pin_in), 32'hA5C3);
    @(negedge clk);
    chk("R3 sync two edges", 32'(pin_in), 32'h1234);

    // R5 pull decode
    wr(4'd1, 32'h0000_0039, 1'b0);
    settle();
    chk("R5 pad_pu", 32'(pad_pu), 32'h0001);
    chk("R5 pad_pd", 32'(pad_pd), 32'h0002);

    // R4 pin0 back to analog forces pull off
    wr(4'd0, 32'h0000_0003, 1'b0);
    settle();
    chk("R4 analog pull off", 32'(pad_pu), 0);
    chk("R4 other pin pd kept", 32'(pad_pd), 32'h0002);

    // R6/R11 push-pull outputs on pins 4-7
    wr(4'd0, 32'h0000_5503, 1'b0);
    wr(4'd6, 32'h0000_0050, 1'b0);
    wr(4'd3, 32'h0000_0B0C, 1'b0);
    settle();
    chk("R6 pad_oe", 32'(pad_oe), 32'h00F0);
    chk("R6 pad_out", 32'(pad_out), 32'h0050);
    chk("R11 speed only on drivers", 32'(pad_speed), 32'h0B00);

    // R7/R11 open drain
    wr(4'd2, 32'h0000_0032, 1'b0);
    settle();
    chk("R7 pad_oe", 32'(pad_oe), 32'h00E0);
    chk("R7 pad_out", 32'(pad_out), 32'h0040);
    chk("R11 pad_od drivers", 32'(pad_od), 32'h0030);

    // R9 set/clear
    wr(4'd7, 32'h0040_0080, 1'b0);
    rd(4'd6, 32'h0000_0090, "R9 set and clear");
    wr(4'd7, 32'h0090_0010, 1'b0);
    rd(4'd6, 32'h0000_0010, "R9 set wins");

    // R8 alternate functions on pins 8/9
    alt_data[3*N +: N]  = 16'hFFFF; alt_oe[3*N +: N]  = 16'hFFFF;
    alt_data[12*N +: N] = 16'h0000; alt_oe[12*N +: N] = 16'h0000;
    alt_data[0 +: N]    = 16'h0200; alt_oe[0 +: N]    = 16'h0200;
    wr(4'd5, 32'h0000_00C3, 1'b0);
    wr(4'd4, 32'h0000_0300, 1'b0);
    wr(4'd0, 32'h000A_5503, 1'b0);
    settle();
    chk("R8 pad_oe", 32'(pad_oe), 32'h01E0);
    chk("R8 pad_out", 32'(pad_out), 32'h0100);
    alt_data[12*N +: N] = 16'h0200; alt_oe[12*N +: N] = 16'h0200;
    settle();
    chk("R8 line dir", 32'(pad_oe), 32'h03E0);
    chk("R8 line data", 32'(pad_out), 32'h0300);

    // R10 security
    wr(4'd9, 32'h0000_00F0, 1'b1);
    rd(4'd9, 32'h0000_00F0, "R10 secure set");
    wr(4'd6, 32'h0000_FFFF, 1'b0);
    rd(4'd6, 32'h0000_FF1F, "R10 odata gated");
    wr(4'd0, 32'h0, 1'b0);
    rd(4'd0, 32'h0000_5500, "R10 mode gated");
    wr(4'd9, 32'h0, 1'b0);
    rd(4'd9, 32'h0000_00F0, "R10 attr locked");
    wr(4'd7, 32'h0010_0000, 1'b0);
    rd(4'd6, 32'h0000_FF1F, "R10 setclr gated");
    wr(4'd7, 32'h0010_0000, 1'b1);
    rd(4'd6, 32'h0000_FF0F, "R10 secure setclr");
    settle();
    chk("R5 pull after input", 32'(pad_pu), 32'h0001);

    // R2 readback
    rd(4'd7, 32'h0, "R2 setclr reads zero");
    rd(4'd1, 32'h0000_0039, "R2 pull readback");
    rd(4'd3, 32'h0000_0B0C, "R2 speed readback");
    rd(4'd5, 32'h0000_00C3, "R2 altsel hi readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule